// File: doc/BRIEF.md
# Serial Channel Error Status Flags

This block keeps the error status of one channel of a multi-mode serial unit, one that can run as a UART, as a clocked serial port or as an I2C-style port. The receive and transmit logic reports events to it as single-cycle strobes and level inputs. The block turns those events into three sticky error flags: framing, parity/acknowledge and overrun. It places them, together with the live transfer-busy and buffer-full levels, in a 16-bit read-only status word.

Software clears a flag by writing a one to the matching bit of a separate clear port. Writing a zero leaves the flag alone. The block tracks internally whether received data is still waiting to be read, and uses that to decide when an overrun has occurred. While the clocked-serial receiver works in snooze mode, the overrun flag is frozen. The framing flag is built only when a parameter asks for it.

Top module: `ser_err_status`

## Requirements
- R1: A synchronous active-low reset drives the whole status word to 0x0000 on the next clock edge.
- R2: The framing flag, status bit 2, sets on the edge that samples `rx_done` high while `rx_stop_ok` is low. A completed reception with `rx_stop_ok` high leaves the flag unchanged.
- R3: The parity/acknowledge flag, status bit 1, sets on the edge that samples either of two conditions: `rx_done` together with `rx_parity_bad`, or `ack_missing`.
- R4: The overrun flag, status bit 0, sets on the edge that samples `rx_load` or `tx_load` while two things hold: received data is still unread and `rx_enable` is high. Received data becomes unread on each `rx_load` and is consumed by `data_read`. No overrun is raised when nothing is unread or when `rx_enable` is low.
- R5: The overrun flag also sets on the edge that samples `slave_tx_late`.
- R6: With `clr_wr` high, each one in `clr_mask` clears one flag on that edge: bit 2 clears framing, bit 1 clears parity/acknowledge and bit 0 clears overrun. Zero bits leave their flags unchanged.
- R7: When a set event and a clear hit the same flag on the same edge, the flag ends up set.
- R8: While `snooze_en` and `csi_mode` are both high, the overrun flag neither sets nor clears. `snooze_en` alone does not freeze it.
- R9: With `FRAME_ERR_EN` = 0, status bit 2 always reads 0.
- R10: Status bit 6 follows `busy` and status bit 5 follows `buf_full` in the same cycle. Bits 15..7, 4 and 3 always read 0.
- R11: Each error flag stays set after its event ends, until it is cleared or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_done | input | 1 | Strobe: UART reception finished |
| rx_stop_ok | input | 1 | Valid stop bit seen, qualified by rx_done |
| rx_parity_bad | input | 1 | Parity mismatch, qualified by rx_done |
| ack_missing | input | 1 | Strobe: no acknowledge during an I2C-style transmit |
| rx_load | input | 1 | Strobe: receive data written into the data register |
| tx_load | input | 1 | Strobe: transmit data written into the data register |
| data_read | input | 1 | Strobe: software read the receive data |
| rx_enable | input | 1 | Level: the channel mode includes reception |
| slave_tx_late | input | 1 | Strobe: slave transmit data not ready in time |
| snooze_en | input | 1 | Level: snooze mode enabled |
| csi_mode | input | 1 | Level: channel runs as a clocked serial port |
| busy | input | 1 | Level: transfer in progress |
| buf_full | input | 1 | Level: data buffer holds valid data |
| clr_wr | input | 1 | Strobe: write to the clear register |
| clr_mask | input | 3 | Write-one-to-clear bits: 2 framing, 1 parity/ack, 0 overrun |
| status | output | 16 | Read-only status word |

## Verification
The assertions assume that every event input is a strobe lasting one cycle. They also assume that `rx_stop_ok` and `rx_parity_bad` carry meaning only in a cycle where `rx_done` is high, and that the mode levels stay steady between edges. The stimulus table meets these assumptions. Each row drives every input for exactly one cycle from the falling edge and returns all strobes to zero in the next row. The checker reads the status word just after the rising edge, where every flag change becomes visible. A second instance, built without the framing flag, is driven from the same rows.

// File: rtl/ser_err_pkg.sv
// Shared constants for the serial error status block.
// Assumes a 16-bit status word and bit positions fixed by the readers of that word.
package ser_err_pkg;
    localparam int STAT_W   = 16;
    localparam int CLR_W    = 3;
    localparam int POS_OVR  = 0;
    localparam int POS_PAR  = 1;
    localparam int POS_FRM  = 2;
    localparam int POS_FULL = 5;
    localparam int POS_BUSY = 6;

    // Error events collected in one cycle
    typedef struct packed {
        logic frm;
        logic par;
        logic ovr;
    } err_evt_t;
endpackage

// File: rtl/err_flag_cell.sv
// One sticky error flag: a set event beats a clear, and freeze holds the value.
// Assumes that set_evt and clr_req are sampled once per clock.
module err_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    input  logic freeze,
    output logic q
);
    // Update the flag: reset, then freeze, then set, then clear
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (!freeze) begin
            if (set_evt)      q <= 1'b1;
            else if (clr_req) q <= 1'b0;
        end
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !freeze) |=> q);
    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt && !freeze) |=> !q);
    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(q));
    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr_req) |=> q);
endmodule

// File: rtl/held_data_tracker.sv
// Tracks whether received data sits unread and raises overrun events.
// Assumes that rx_load, tx_load, data_read and slave_tx_late are one-cycle strobes.
module held_data_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_load,
    input  logic tx_load,
    input  logic data_read,
    input  logic rx_enable,
    input  logic slave_tx_late,
    output logic ovr_evt
);
    logic held;

    // Record unread receive data; a new load outranks a read in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)         held <= 1'b0;
        else if (rx_load)   held <= 1'b1;
        else if (data_read) held <= 1'b0;
    end

    // Detect a write over unread data, or late slave transmit data
    always_comb begin
        ovr_evt = ((rx_load || tx_load) && held && rx_enable) || slave_tx_late;
    end

    // R4
    held_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> held);
    // R4
    held_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_read && !rx_load) |=> !held);
endmodule

// File: rtl/status_word_pack.sv
// Places the flags and live levels at their fixed positions in the status word.
// Assumes that every position not listed reads as zero.
module status_word_pack
    import ser_err_pkg::*;
(
    input  err_evt_t          flags,
    input  logic              busy,
    input  logic              buf_full,
    output logic [STAT_W-1:0] word
);
    // Assemble the read-only word
    always_comb begin
        word           = '0;
        word[POS_OVR]  = flags.ovr;
        word[POS_PAR]  = flags.par;
        word[POS_FRM]  = flags.frm;
        word[POS_FULL] = buf_full;
        word[POS_BUSY] = busy;
    end

    // R10
    always_comb begin
        zero_bits_chk: assert (word[STAT_W-1:POS_BUSY+1] == '0 && word[4:3] == 2'b00);
    end
endmodule

// File: rtl/ser_err_status.sv
// Error status block for one serial channel: three sticky flags plus live levels.
// Assumes single-cycle event strobes, and that rx_stop_ok and rx_parity_bad
// carry meaning only while rx_done is high.
module ser_err_status
    import ser_err_pkg::*;
#(
    parameter bit FRAME_ERR_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done,
    input  logic              rx_stop_ok,
    input  logic              rx_parity_bad,
    input  logic              ack_missing,
    input  logic              rx_load,
    input  logic              tx_load,
    input  logic              data_read,
    input  logic              rx_enable,
    input  logic              slave_tx_late,
    input  logic              snooze_en,
    input  logic              csi_mode,
    input  logic              busy,
    input  logic              buf_full,
    input  logic              clr_wr,
    input  logic [CLR_W-1:0]  clr_mask,
    output logic [STAT_W-1:0] status
);
    err_evt_t evt;
    err_evt_t flags;
    logic [CLR_W-1:0] clr_req;
    logic ovr_freeze;
    logic ovr_raw;

    held_data_tracker u_held (
        .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .tx_load(tx_load),
        .data_read(data_read), .rx_enable(rx_enable),
        .slave_tx_late(slave_tx_late), .ovr_evt(ovr_raw)
    );

    // Derive the set events and the per-flag clear requests
    always_comb begin
        evt.frm    = rx_done && !rx_stop_ok;
        evt.par    = (rx_done && rx_parity_bad) || ack_missing;
        evt.ovr    = ovr_raw;
        clr_req    = clr_wr ? clr_mask : '0;
        ovr_freeze = snooze_en && csi_mode;
    end

    err_flag_cell u_par (
        .clk(clk), .rst_n(rst_n), .set_evt(evt.par), .clr_req(clr_req[POS_PAR]),
        .freeze(1'b0), .q(flags.par)
    );
    err_flag_cell u_ovr (
        .clk(clk), .rst_n(rst_n), .set_evt(evt.ovr), .clr_req(clr_req[POS_OVR]),
        .freeze(ovr_freeze), .q(flags.ovr)
    );

    generate
        if (FRAME_ERR_EN) begin : g_frm
            err_flag_cell u_frm (
                .clk(clk), .rst_n(rst_n), .set_evt(evt.frm), .clr_req(clr_req[POS_FRM]),
                .freeze(1'b0), .q(flags.frm)
            );
        end else begin : g_no_frm
            assign flags.frm = 1'b0;
        end
    endgenerate

    status_word_pack u_pack (
        .flags(flags), .busy(busy), .buf_full(buf_full), .word(status)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (status[POS_FRM:POS_OVR] == 3'b000));
    // R9
    no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !FRAME_ERR_EN |-> !status[POS_FRM]);
    // R2
    frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (FRAME_ERR_EN && rx_done && !rx_stop_ok) |=> status[POS_FRM]);
    // R5
    late_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_tx_late && !(snooze_en && csi_mode)) |=> status[POS_OVR]);
endmodule

// File: tb/sim_ser_err_status.sv
// Table-driven bench: each row drives one cycle and checks the word after the edge.
module sim_ser_err_status;
    logic clk = 1'b0;
    logic rst_n;
    logic rx_done, rx_stop_ok, rx_parity_bad, ack_missing, rx_load, tx_load;
    logic data_read, rx_enable, slave_tx_late, snooze_en, csi_mode, busy, buf_full;
    logic clr_wr;
    logic [2:0] clr_mask;
    logic [15:0] status, status_nf;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ser_err_status #(.FRAME_ERR_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_stop_ok(rx_stop_ok),
        .rx_parity_bad(rx_parity_bad), .ack_missing(ack_missing), .rx_load(rx_load),
        .tx_load(tx_load), .data_read(data_read), .rx_enable(rx_enable),
        .slave_tx_late(slave_tx_late), .snooze_en(snooze_en), .csi_mode(csi_mode),
        .busy(busy), .buf_full(buf_full), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .status(status)
    );
    ser_err_status #(.FRAME_ERR_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_stop_ok(rx_stop_ok),
        .rx_parity_bad(rx_parity_bad), .ack_missing(ack_missing), .rx_load(rx_load),
        .tx_load(tx_load), .data_read(data_read), .rx_enable(rx_enable),
        .slave_tx_late(slave_tx_late), .snooze_en(snooze_en), .csi_mode(csi_mode),
        .busy(busy), .buf_full(buf_full), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .status(status_nf)
    );

    // Stimulus bits: [2:0] clear mask, then one bit per input
    localparam logic [31:0] CW  = 32'h1 << 16, RXD = 32'h1 << 17, STP = 32'h1 << 18;
    localparam logic [31:0] PB  = 32'h1 << 19, ACK = 32'h1 << 20, RL  = 32'h1 << 21;
    localparam logic [31:0] TL  = 32'h1 << 22, RD  = 32'h1 << 23, EN  = 32'h1 << 24;
    localparam logic [31:0] LT  = 32'h1 << 25, SZ  = 32'h1 << 26, CSI = 32'h1 << 27;
    localparam logic [31:0] BSY = 32'h1 << 28, FUL = 32'h1 << 29;
    localparam int NV = 27;
    // Row: {requirement, expected word, stimulus}
    localparam logic [51:0] VEC [NV] = '{
        {4'd1,  16'h0000, 32'h0},                       // R1 idle after reset
        {4'd2,  16'h0000, RXD | STP},                   // R2 good stop bit
        {4'd2,  16'h0004, RXD},                         // R2 missing stop bit
        {4'd11, 16'h0004, 32'h0},                       // R11 sticky
        {4'd6,  16'h0004, CW},                          // R6 zero mask no effect
        {4'd6,  16'h0000, CW | 32'h4},                  // R6 clear framing
        {4'd3,  16'h0002, RXD | STP | PB},              // R3 parity mismatch
        {4'd6,  16'h0000, CW | 32'h2},                  // R6 clear parity
        {4'd3,  16'h0002, ACK},                         // R3 missing ack
        {4'd6,  16'h0000, CW | 32'h2},                  // R6
        {4'd4,  16'h0000, RL | EN},                     // R4 first load, no overrun
        {4'd4,  16'h0001, RL | EN},                     // R4 load over unread data
        {4'd6,  16'h0000, CW | 32'h1 | RD | EN},        // R6 clear overrun, read data
        {4'd4,  16'h0000, RL | EN},                     // R4 data unread again
        {4'd4,  16'h0000, TL},                          // R4 receive disabled
        {4'd4,  16'h0001, TL | EN},                     // R4 transmit write over unread
        {4'd6,  16'h0000, CW | 32'h1},                  // R6
        {4'd5,  16'h0001, LT},                          // R5 late slave data
        {4'd7,  16'h0001, CW | 32'h1 | LT},             // R7 set beats clear
        {4'd7,  16'h0005, CW | 32'h4 | RXD},            // R7 framing set beats clear
        {4'd8,  16'h0005, CW | 32'h1 | SZ | CSI},       // R8 frozen, no clear
        {4'd6,  16'h0004, CW | 32'h1},                  // R6
        {4'd8,  16'h0004, TL | EN | SZ | CSI},          // R8 frozen, no set
        {4'd8,  16'h0005, TL | EN | SZ},                // R8 snooze alone
        {4'd10, 16'h0045, BSY},                         // R10 busy level
        {4'd10, 16'h0025, FUL},                         // R10 full level
        {4'd6,  16'h0000, CW | 32'h7}                   // R6 clear all
    };

    task automatic drive(input logic [31:0] s);
        clr_mask = s[2:0];   clr_wr = s[16];   rx_done = s[17];  rx_stop_ok = s[18];
        rx_parity_bad = s[19]; ack_missing = s[20]; rx_load = s[21]; tx_load = s[22];
        data_read = s[23];   rx_enable = s[24]; slave_tx_late = s[25];
        snooze_en = s[26];   csi_mode = s[27]; busy = s[28];     buf_full = s[29];
    endtask

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        drive(32'h0);
        repeat (2) @(posedge clk);
        #1 check(1, status, 16'h0000);      // R1 reset state
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][31:0]);
            @(posedge clk);
            #1;
            check(int'(VEC[i][51:48]), status, VEC[i][47:32]);
            check(9, status_nf, VEC[i][47:32] & 16'hFFFB); // R9 no framing bit
            @(negedge clk);
        end
        // R1: reset clears set flags
        drive(RXD | ACK | LT);
        @(posedge clk); #1 check(2, status, 16'h0007);
        @(negedge clk) drive(32'h0); rst_n = 1'b0;
        @(posedge clk); #1 check(1, status, 16'h0000);
        @(negedge clk) rst_n = 1'b1;
        // R4: load and read in one cycle keeps data unread
        drive(RL | RD | EN);
        @(posedge clk); @(negedge clk) drive(RL | EN);
        @(posedge clk); #1 check(4, status, 16'h0001);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin repeat (5000) @(posedge clk); n_chk++; n_bad++;
                  $display("FAIL watchdog actual=hung expected=done"); end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule